// File: doc/BRIEF.md
# Filtered I/O Traffic Performance Monitor

This block counts memory traffic that devices behind one I/O root complex send towards memory. Each cycle it may see one request, tagged with the root port it came in on, the requester's bus/device/function identifier, the class of memory it targets, its direction and its byte count. It may also see a pulse that marks the completion of an earlier read. A small set of event counters, each with its own event selector, source filter and destination filter, decides what gets accumulated. A free-running cycle counter gives the time base. From these, rates, bandwidth and read latency can be derived.

Software programs the unit through a plain single-cycle register port: one write strobe, an address, write data, and read data that is decoded combinationally from the address. Source filtering works either by a mask of root ports or by one exact requester identifier. The identifier filter is a single resource shared by all counters. Writes that would break that rule are refused and raise an error flag.

Top module: `io_traffic_monitor`

## Requirements
- R1: After a synchronous active-low reset, the control register, every selector, source filter, destination filter, event counter and the cycle counter read as zero, and `cfg_err` is low.
- R2: Selector code 0 adds the byte count of each matching read, 1 the byte count of each matching write, 2 adds one per matching read, and 3 adds one per matching write. Codes 5, 6 and 7 never change the counter.
- R3: An outstanding-read count rises by one on each read issued (`req_valid` with `req_is_write` low) and falls by one on each `rd_done`. Issue and completion together leave it unchanged, and a completion while it is zero is ignored. Selector code 4 adds the count held at the start of each cycle to the counter, every enabled cycle, with no filtering.
- R4: The cycle counter (read at 0x60 low word, 0x61 high word) rises by one every cycle in which the global enable (control bit 0) and the cycle enable (control bit NUM_CNT+1) are both set.
- R5: Source filter bits 7:0 are a root-port mask, bit p selecting port p. A mask of zero selects all ports. This applies while no requester-ID filter is active.
- R6: Destination filter bits are: bit 0 local system memory (class code 0), bit 1 local GPU memory (1), bit 2 local peer I/O (2), bit 3 local CXL memory (3), bit 4 remote memory (4). A request counts only when the bit for its class is set. An all-zero filter selects all five classes. Class codes 5 to 7 never count.
- R7: Source filter bits 23:8 hold a requester ID (bus in 15:8, device in 7:3, function in 2:0) and bit 24 enables it. While any enabled counter holds an enabled ID, every event counter counts only requests carrying that ID, whatever their port. The lowest-numbered such counter supplies the value.
- R8: A source filter write with bit 24 set and a nonzero port mask is ignored, and it sets `cfg_err`.
- R9: A source filter write with bit 24 set is also ignored, and sets `cfg_err`, when another enabled counter holds an enabled requester ID with a different value.
- R10: An accepted source filter write clears `cfg_err`. Writing zero to a counter's filters restores counting from all ports to all classes.
- R11: An event counter advances only when the global enable and its own enable (control bit k+1) are both set. Otherwise it holds its value.
- R12: Register map: control at 0x00. Counter k has its selector at 0x10+4k, source filter at 0x11+4k and destination filter at 0x12+4k. Its value reads at 0x40+2k (bits 31:0) and 0x41+2k (bits 63:32). Any write to 0x40+2k or 0x60 clears that counter, and the clear overrides an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_write | input | 1 | 1 for a write request, 0 for a read |
| req_port | input | $clog2(NUM_PORTS) | Root port index of the request |
| req_rid | input | 16 | Requester bus/device/function identifier |
| req_dst | input | 3 | Destination memory class code |
| req_bytes | input | BYTE_W | Byte count of the request |
| rd_done | input | 1 | One earlier read completes this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cfg_err | output | 1 | Last source filter write was refused |

## Verification
The bench builds the block with its defaults: four 64-bit event counters, eight ports, 12-bit byte counts and an 8-bit outstanding count. Four counters are enough to run all four traffic events at once, to put two counters in conflicting requester-ID settings, and to disable one counter while its neighbours keep counting. Random destination codes include the three illegal ones, so rejection of classes 5 to 7 is exercised. With these widths the random traffic never comes near outstanding saturation or a carry into a counter's high word. Those high words are only checked to stay zero.

// File: rtl/iotm_pkg.sv
`timescale 1ns/1ps
// Shared constants and event codes of the I/O traffic monitor.
// Assumes an 8-bit register address space and 32-bit register data.
package iotm_pkg;

    localparam int ADDR_W  = 8;
    localparam int NUM_DST = 5;
    localparam int RID_W   = 16;

    typedef enum logic [2:0] {
        EV_RD_BYTES = 3'd0,
        EV_WR_BYTES = 3'd1,
        EV_RD_REQS  = 3'd2,
        EV_WR_REQS  = 3'd3,
        EV_RD_OUTS  = 3'd4
    } iotm_event_e;

    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
    localparam logic [ADDR_W-1:0] A_CFG_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] A_CYC_LO   = 8'h60;
    localparam logic [ADDR_W-1:0] A_CYC_HI   = 8'h61;

endpackage

// File: rtl/iotm_outstanding.sv
`timescale 1ns/1ps
// Up/down count of reads issued but not yet completed.
// Assumes at most one issue and one completion per cycle. A completion
// at zero is dropped and the count saturates at its maximum.
module iotm_outstanding #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_issue,
    input  logic             rd_done,
    output logic [OUT_W-1:0] outs
);

    localparam logic [OUT_W-1:0] OUT_MAX = '1;

    logic step_up;
    logic step_dn;

    // Qualify the two step requests against the current count.
    always_comb begin
        step_up = rd_issue;
        step_dn = rd_done && (outs != '0);
    end

    // Move the count by at most one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outs <= '0;
        end else if (step_up && !step_dn && (outs != OUT_MAX)) begin
            outs <= outs + 1'b1;
        end else if (step_dn && !step_up) begin
            outs <= outs - 1'b1;
        end
    end

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (outs == '0 && rd_done && !rd_issue) |=> (outs == '0));

    assert_balanced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && rd_done && outs != '0) |=> $stable(outs));

endmodule

// File: rtl/iotm_event_match.sv
`timescale 1ns/1ps
// Per-counter match logic: applies source and destination filters to the
// current request and returns the amount to add for the selected event.
// Assumes NUM_PORTS is a power of two; the shared requester-ID filter,
// when active, replaces the port mask.
module iotm_event_match
    import iotm_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PORT_W    = 3,
    parameter int BYTE_W    = 12,
    parameter int OUT_W     = 8,
    parameter int ADD_W     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           evsel,
    input  logic [NUM_PORTS-1:0] port_mask,
    input  logic [NUM_DST-1:0]   dst_mask,
    input  logic                 rid_on,
    input  logic [RID_W-1:0]     rid_val,
    input  logic                 req_valid,
    input  logic                 req_is_write,
    input  logic [PORT_W-1:0]    req_port,
    input  logic [RID_W-1:0]     req_rid,
    input  logic [2:0]           req_dst,
    input  logic [BYTE_W-1:0]    req_bytes,
    input  logic [OUT_W-1:0]     outs,
    output logic [ADD_W-1:0]     add_amt
);

    logic [NUM_PORTS-1:0] eff_ports;
    logic [7:0]           eff_dst;
    logic                 src_ok;
    logic                 dst_ok;
    logic                 hit;

    // Resolve default filters and decide whether the request matches.
    always_comb begin
        eff_ports = (port_mask == '0) ? '1 : port_mask;
        eff_dst   = {3'b000, ((dst_mask == '0) ? {NUM_DST{1'b1}} : dst_mask)};
        src_ok    = rid_on ? (req_rid == rid_val) : eff_ports[req_port];
        dst_ok    = eff_dst[req_dst];
        hit       = req_valid && src_ok && dst_ok;
    end

    // Pick the increment that belongs to the selected event.
    always_comb begin
        add_amt = '0;
        case (iotm_event_e'(evsel))
            EV_RD_BYTES: if (hit && !req_is_write) add_amt = ADD_W'(req_bytes);
            EV_WR_BYTES: if (hit &&  req_is_write) add_amt = ADD_W'(req_bytes);
            EV_RD_REQS:  if (hit && !req_is_write) add_amt = ADD_W'(1'b1);
            EV_WR_REQS:  if (hit &&  req_is_write) add_amt = ADD_W'(1'b1);
            EV_RD_OUTS:  add_amt = ADD_W'(outs);
            default:     add_amt = '0;
        endcase
    end

    assert_unused_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evsel > 3'd4) |-> (add_amt == '0));

    assert_idle_adds_nothing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && evsel != 3'd4) |-> (add_amt == '0));

endmodule

// File: rtl/iotm_filter_guard.sv
`timescale 1ns/1ps
// Owns the single requester-ID filter: picks the active ID from the
// enabled counters and vets each source filter write against port/ID
// exclusivity and against IDs already held by other enabled counters.
// Assumes at most one source filter write per cycle.
module iotm_filter_guard
    import iotm_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int NUM_PORTS = 8,
    parameter int SRC_W     = NUM_PORTS + RID_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0][SRC_W-1:0] src_all,
    input  logic [NUM_CNT-1:0]            cnt_en,
    input  logic [NUM_CNT-1:0]            wr_src_oh,
    input  logic [SRC_W-1:0]              wr_val,
    output logic                          accept,
    output logic                          rid_on,
    output logic [RID_W-1:0]              rid_val
);

    localparam int RID_LSB = NUM_PORTS;
    localparam int RID_EN  = NUM_PORTS + RID_W;

    logic excl_bad;
    logic id_clash;

    // Check the incoming value for both refusal reasons.
    always_comb begin
        excl_bad = wr_val[RID_EN] && (wr_val[NUM_PORTS-1:0] != '0);
        id_clash = 1'b0;
        for (int j = 0; j < NUM_CNT; j++) begin
            if (wr_val[RID_EN] && cnt_en[j] && !wr_src_oh[j] && src_all[j][RID_EN] &&
                (src_all[j][RID_EN-1:RID_LSB] != wr_val[RID_EN-1:RID_LSB]))
                id_clash = 1'b1;
        end
        accept = !excl_bad && !id_clash;
    end

    // The lowest-numbered enabled counter with an ID supplies the shared value.
    always_comb begin
        rid_on  = 1'b0;
        rid_val = '0;
        for (int j = NUM_CNT - 1; j >= 0; j--) begin
            if (cnt_en[j] && src_all[j][RID_EN]) begin
                rid_on  = 1'b1;
                rid_val = src_all[j][RID_EN-1:RID_LSB];
            end
        end
    end

    assert_single_src_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_src_oh));

endmodule

// File: rtl/io_traffic_monitor.sv
`timescale 1ns/1ps
// Performance monitor for one I/O root complex: NUM_CNT filtered event
// counters, one cycle counter and a register port for programming and
// reading them. Assumes the request sideband is valid with req_valid and
// that software issues at most one register write per cycle.
module io_traffic_monitor
    import iotm_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int NUM_PORTS = 8,
    parameter int CNT_W     = 64,
    parameter int BYTE_W    = 12,
    parameter int OUT_W     = 8,
    parameter int DATA_W    = 32,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_write,
    input  logic [PORT_W-1:0] req_port,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [2:0]        req_dst,
    input  logic [BYTE_W-1:0] req_bytes,
    input  logic              rd_done,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cfg_err
);

    localparam int SRC_W  = NUM_PORTS + RID_W + 1;
    localparam int ADD_W  = (BYTE_W > OUT_W) ? BYTE_W : OUT_W;
    localparam int CTRL_W = NUM_CNT + 2;

    logic                             glob_en;
    logic [NUM_CNT-1:0]               cnt_en;
    logic                             cyc_en;
    logic [NUM_CNT-1:0][2:0]          sel_q;
    logic [NUM_CNT-1:0][SRC_W-1:0]    src_q;
    logic [NUM_CNT-1:0][NUM_DST-1:0]  dst_q;
    logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_q;
    logic [NUM_CNT-1:0][ADD_W-1:0]    add_amt;
    logic [CNT_W-1:0]                 cyc_q;
    logic [NUM_CNT-1:0]               wr_sel;
    logic [NUM_CNT-1:0]               wr_src;
    logic [NUM_CNT-1:0]               wr_dst;
    logic [NUM_CNT-1:0]               wr_clr;
    logic                             wr_ctrl;
    logic                             wr_cyc_clr;
    logic                             src_accept;
    logic                             rid_on;
    logic [RID_W-1:0]                 rid_val;
    logic [OUT_W-1:0]                 outs;
    logic                             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:SRC_W];
    assign wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
    assign wr_cyc_clr   = reg_wr && (reg_addr == A_CYC_LO);

    iotm_outstanding #(.OUT_W(OUT_W)) u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (req_valid && !req_is_write),
        .rd_done  (rd_done),
        .outs     (outs)
    );

    iotm_filter_guard #(.NUM_CNT(NUM_CNT), .NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_all   (src_q),
        .cnt_en    (cnt_en),
        .wr_src_oh (wr_src),
        .wr_val    (reg_wdata[SRC_W-1:0]),
        .accept    (src_accept),
        .rid_on    (rid_on),
        .rid_val   (rid_val)
    );

    // Control register: global, per-counter and cycle enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cyc_en, cnt_en, glob_en} <= '0;
        end else if (wr_ctrl) begin
            {cyc_en, cnt_en, glob_en} <= reg_wdata[CTRL_W-1:0];
        end
    end

    // Error flag reflects the outcome of the latest source filter write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (wr_src != '0) begin
            cfg_err <= !src_accept;
        end
    end

    // Cycle counter: clear overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (wr_cyc_clr) begin
            cyc_q <= '0;
        end else if (glob_en && cyc_en) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        assign wr_sel[k] = reg_wr && (reg_addr == ADDR_W'(A_CFG_BASE + 4 * k));
        assign wr_src[k] = reg_wr && (reg_addr == ADDR_W'(A_CFG_BASE + 4 * k + 1));
        assign wr_dst[k] = reg_wr && (reg_addr == ADDR_W'(A_CFG_BASE + 4 * k + 2));
        assign wr_clr[k] = reg_wr && (reg_addr == ADDR_W'(A_CNT_BASE + 2 * k));

        // Configuration of this counter; source writes are vetted first.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[k] <= '0;
                src_q[k] <= '0;
                dst_q[k] <= '0;
            end else begin
                if (wr_sel[k])               sel_q[k] <= reg_wdata[2:0];
                if (wr_src[k] && src_accept) src_q[k] <= reg_wdata[SRC_W-1:0];
                if (wr_dst[k])               dst_q[k] <= reg_wdata[NUM_DST-1:0];
            end
        end

        iotm_event_match #(
            .NUM_PORTS (NUM_PORTS),
            .PORT_W    (PORT_W),
            .BYTE_W    (BYTE_W),
            .OUT_W     (OUT_W),
            .ADD_W     (ADD_W)
        ) u_match (
            .clk          (clk),
            .rst_n        (rst_n),
            .evsel        (sel_q[k]),
            .port_mask    (src_q[k][NUM_PORTS-1:0]),
            .dst_mask     (dst_q[k]),
            .rid_on       (rid_on),
            .rid_val      (rid_val),
            .req_valid    (req_valid),
            .req_is_write (req_is_write),
            .req_port     (req_port),
            .req_rid      (req_rid),
            .req_dst      (req_dst),
            .req_bytes    (req_bytes),
            .outs         (outs),
            .add_amt      (add_amt[k])
        );

        // Event accumulator: clear overrides counting.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[k] <= '0;
            end else if (wr_clr[k]) begin
                cnt_q[k] <= '0;
            end else if (glob_en && cnt_en[k]) begin
                cnt_q[k] <= cnt_q[k] + CNT_W'(add_amt[k]);
            end
        end

        assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!(glob_en && cnt_en[k]) && !wr_clr[k]) |=> $stable(cnt_q[k]));

        assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
            wr_clr[k] |=> (cnt_q[k] == '0));
    end

    // Register read decode.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)   reg_rdata = DATA_W'({cyc_en, cnt_en, glob_en});
        if (reg_addr == A_CYC_LO) reg_rdata = DATA_W'(cyc_q);
        if (reg_addr == A_CYC_HI) reg_rdata = DATA_W'(cyc_q >> DATA_W);
        for (int k = 0; k < NUM_CNT; k++) begin
            if (reg_addr == ADDR_W'(A_CFG_BASE + 4 * k))     reg_rdata = DATA_W'(sel_q[k]);
            if (reg_addr == ADDR_W'(A_CFG_BASE + 4 * k + 1)) reg_rdata = DATA_W'(src_q[k]);
            if (reg_addr == ADDR_W'(A_CFG_BASE + 4 * k + 2)) reg_rdata = DATA_W'(dst_q[k]);
            if (reg_addr == ADDR_W'(A_CNT_BASE + 2 * k))     reg_rdata = DATA_W'(cnt_q[k]);
            if (reg_addr == ADDR_W'(A_CNT_BASE + 2 * k + 1)) reg_rdata = DATA_W'(cnt_q[k] >> DATA_W);
        end
    end

    assert_cycle_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cyc_en && !wr_cyc_clr) |=> (cyc_q == $past(cyc_q) + 1'b1));

    assert_exclusive_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_src != '0) && reg_wdata[SRC_W-1] && (reg_wdata[NUM_PORTS-1:0] != '0))
        |=> (cfg_err && $stable(src_q)));

endmodule

// File: tb/sim_io_traffic_monitor.sv
`timescale 1ns/1ps
module sim_io_traffic_monitor;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_is_write, rd_done, reg_wr;
    logic [2:0]  req_port, req_dst;
    logic [15:0] req_rid;
    logic [11:0] req_bytes;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        cfg_err;

    always #2 clk = ~clk;

    io_traffic_monitor #(.NUM_CNT(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_write(req_is_write),
        .req_port(req_port), .req_rid(req_rid), .req_dst(req_dst), .req_bytes(req_bytes),
        .rd_done(rd_done), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cfg_err(cfg_err)
    );

    int    checks = 0;
    int    errors = 0;
    int    tick_n = 0;
    bit    finished = 0;
    string phase = "R1";

    // Behavioural reference state.
    logic [31:0]     m_ctrl;
    logic [2:0]      m_sel [NC];
    logic [24:0]     m_src [NC];
    logic [4:0]      m_dst [NC];
    longint unsigned m_cnt [NC];
    longint unsigned m_cyc;
    int              m_outs;
    bit              m_err;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit         shared_on = 0;
        logic [15:0] srid = '0;
        int         nxt;
        for (int j = NC - 1; j >= 0; j--)
            if (m_ctrl[j+1] && m_src[j][24]) begin shared_on = 1; srid = m_src[j][23:8]; end
        for (int k = 0; k < NC; k++) begin
            if (m_ctrl[0] && m_ctrl[k+1]) begin
                logic [7:0] pm;
                logic [4:0] dm;
                bit sok, dok, rd, wr;
                pm  = (m_src[k][7:0] == 0) ? 8'hff : m_src[k][7:0];
                dm  = (m_dst[k] == 0) ? 5'h1f : m_dst[k];
                sok = shared_on ? (req_rid == srid) : pm[req_port];
                dok = (req_dst < 5) && dm[req_dst];
                rd  = req_valid && !req_is_write && sok && dok;
                wr  = req_valid &&  req_is_write && sok && dok;
                case (m_sel[k])
                    3'd0: if (rd) m_cnt[k] += req_bytes;
                    3'd1: if (wr) m_cnt[k] += req_bytes;
                    3'd2: if (rd) m_cnt[k] += 1;
                    3'd3: if (wr) m_cnt[k] += 1;
                    3'd4: m_cnt[k] += m_outs;
                    default: ;
                endcase
            end
        end
        if (m_ctrl[0] && m_ctrl[NC+1]) m_cyc++;
        nxt = m_outs;
        if (req_valid && !req_is_write) nxt++;
        if (rd_done && m_outs > 0) nxt--;
        if (nxt > 255) nxt = 255;
        m_outs = nxt;
        if (reg_wr) begin
            if (reg_addr == 8'h00) m_ctrl = reg_wdata & 32'h3f;
            if (reg_addr == 8'h60) m_cyc = 0;
            for (int k = 0; k < NC; k++) begin
                if (reg_addr == 8'(8'h10 + 4*k)) m_sel[k] = reg_wdata[2:0];
                if (reg_addr == 8'(8'h12 + 4*k)) m_dst[k] = reg_wdata[4:0];
                if (reg_addr == 8'(8'h40 + 2*k)) m_cnt[k] = 0;
                if (reg_addr == 8'(8'h11 + 4*k)) begin
                    bit bad = reg_wdata[24] && (reg_wdata[7:0] != 0);
                    for (int j = 0; j < NC; j++)
                        if (j != k && m_ctrl[j+1] && m_src[j][24] && reg_wdata[24] &&
                            m_src[j][23:8] != reg_wdata[23:8]) bad = 1;
                    m_err = bad;
                    if (!bad) m_src[k] = reg_wdata[24:0];
                end
            end
        end
    endtask

    // One clock: update the model, let the edge pass, compare one counter and the flag.
    task automatic tick();
        int idx;
        model_step();
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; rd_done = 0; reg_wr = 0;
        idx = tick_n % (NC + 1);
        reg_addr = (idx < NC) ? 8'(8'h40 + 2*idx) : 8'h60;
        #0.2;
        check({phase, " count"}, 64'(reg_rdata), (idx < NC) ? 64'(m_cnt[idx][31:0]) : 64'(m_cyc[31:0]));
        check({phase, " cfg_err"}, 64'(cfg_err), 64'(m_err));
        tick_n++;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [63:0] exp);
        reg_addr = a;
        #0.05;
        check(tag, 64'(reg_rdata), exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        tick();
    endtask

    task automatic req(logic [2:0] port, bit w, logic [15:0] rid, logic [2:0] dst, logic [11:0] b);
        req_valid = 1; req_is_write = w; req_port = port; req_rid = rid; req_dst = dst; req_bytes = b;
        tick();
    endtask

    task automatic traffic(int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom % 3;
            req_valid    = ($urandom % 4) != 0;
            req_is_write = $urandom % 2;
            req_port     = 3'($urandom);
            req_rid      = (r == 0) ? 16'h2781 : (r == 1) ? 16'h0180 : 16'($urandom);
            req_dst      = 3'($urandom);
            req_bytes    = 12'($urandom);
            rd_done      = ($urandom % 3) == 0;
            tick();
        end
    endtask

    task automatic clear_all();
        for (int k = 0; k < NC; k++) wr(8'(8'h40 + 2*k), 0);
    endtask

    task automatic cfg(int k, logic [2:0] sel, logic [24:0] src, logic [4:0] dst);
        wr(8'(8'h10 + 4*k), 32'(sel));
        wr(8'(8'h11 + 4*k), 32'(src));
        wr(8'(8'h12 + 4*k), 32'(dst));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ctrl = 0; m_cyc = 0; m_outs = 0; m_err = 0;
        for (int k = 0; k < NC; k++) begin m_sel[k] = 0; m_src[k] = 0; m_dst[k] = 0; m_cnt[k] = 0; end
        rst_n = 0; req_valid = 0; req_is_write = 0; rd_done = 0; reg_wr = 0;
        req_port = 0; req_rid = 0; req_dst = 0; req_bytes = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #0.2;
        // R1: everything zero after reset
        rd_chk("R1 ctrl", 8'h00, 0);
        rd_chk("R1 sel0", 8'h10, 0);
        rd_chk("R1 src3", 8'h1d, 0);
        rd_chk("R1 dst2", 8'h1a, 0);
        rd_chk("R1 cnt1", 8'h42, 0);
        rd_chk("R1 cyc", 8'h60, 0);
        check("R1 cfg_err", 64'(cfg_err), 0);
        tick();

        // R2: four traffic events at once under random traffic
        phase = "R2";
        for (int k = 0; k < NC; k++) cfg(k, 3'(k), 0, 0);
        wr(8'h00, 32'h3f);
        traffic(300);
        for (int k = 0; k < NC; k++) rd_chk("R2 high word", 8'(8'h41 + 2*k), 64'(m_cnt[k] >> 32));

        // R3: cumulative outstanding reads, directed
        phase = "R3";
        cfg(0, 3'd4, 0, 0);
        for (int i = 0; i < 300; i++) begin rd_done = 1; tick(); end
        wr(8'h40, 0);
        req(0, 0, 0, 0, 1);
        req(0, 0, 0, 0, 1);
        req_valid = 1; req_is_write = 0; rd_done = 1; tick();
        rd_done = 1; tick();
        rd_done = 1; tick();
        rd_done = 1; tick();
        tick();
        rd_chk("R3 cum outstanding", 8'h40, 6);
        traffic(200);

        // R4: cycle counter
        phase = "R4";
        wr(8'h60, 0);
        repeat (10) tick();
        rd_chk("R4 cycles", 8'h60, 10);
        rd_chk("R4 cycles hi", 8'h61, 0);

        // R5: port masks
        phase = "R5";
        cfg(0, 3'd2, 25'h05, 0);
        cfg(1, 3'd2, 25'h80, 0);
        cfg(2, 3'd2, 25'h00, 0);
        cfg(3, 3'd3, 25'h02, 0);
        clear_all();
        req(0, 0, 16'h1111, 0, 4);
        req(2, 0, 16'h1111, 1, 4);
        req(7, 0, 16'h1111, 2, 4);
        req(1, 0, 16'h1111, 3, 4);
        req(1, 1, 16'h1111, 4, 4);
        rd_chk("R5 mask 0x05", 8'h40, 2);
        rd_chk("R5 mask 0x80", 8'h42, 1);
        rd_chk("R5 mask zero", 8'h44, 4);
        rd_chk("R5 write mask 0x02", 8'h46, 1);
        traffic(200);

        // R6: destination classes
        phase = "R6";
        cfg(0, 3'd0, 0, 5'h01);
        cfg(1, 3'd0, 0, 5'h12);
        cfg(2, 3'd0, 0, 5'h00);
        cfg(3, 3'd1, 0, 5'h08);
        clear_all();
        req(3, 0, 0, 0, 10);
        req(3, 0, 0, 1, 20);
        req(3, 0, 0, 4, 40);
        req(3, 0, 0, 6, 80);
        req(3, 1, 0, 3, 5);
        rd_chk("R6 system", 8'h40, 10);
        rd_chk("R6 gpu+remote", 8'h42, 60);
        rd_chk("R6 all classes", 8'h44, 70);
        rd_chk("R6 cxl writes", 8'h46, 5);
        traffic(200);

        // R7: shared requester-ID filter
        phase = "R7";
        cfg(0, 3'd2, 25'h01, 0);
        cfg(1, 3'd2, {1'b1, 16'h2781, 8'h00}, 0);
        cfg(2, 3'd2, 0, 0);
        cfg(3, 3'd2, 0, 0);
        clear_all();
        req(3, 0, 16'h2781, 0, 1);
        req(0, 0, 16'h2780, 0, 1);
        req(0, 0, 16'h2781, 2, 1);
        for (int k = 0; k < NC; k++) rd_chk("R7 id filter", 8'(8'h40 + 2*k), 2);
        traffic(200);

        // R8: exclusivity refused
        phase = "R8";
        wr(8'h19, {7'b0, 1'b1, 16'h2781, 8'h01});
        check("R8 cfg_err", 64'(cfg_err), 1);
        rd_chk("R8 src kept", 8'h19, 0);

        // R9: conflicting ID refused
        phase = "R9";
        wr(8'h1d, {7'b0, 1'b1, 16'h1234, 8'h00});
        check("R9 cfg_err", 64'(cfg_err), 1);
        rd_chk("R9 src kept", 8'h1d, 0);

        // R10: matching ID accepted clears the flag; zero restores defaults
        phase = "R10";
        wr(8'h1d, {7'b0, 1'b1, 16'h2781, 8'h00});
        check("R10 cfg_err cleared", 64'(cfg_err), 0);
        rd_chk("R10 src written", 8'h1d, {39'b0, 1'b1, 16'h2781, 8'h00});
        wr(8'h15, 0);
        wr(8'h1d, 0);
        wr(8'h11, 0);
        clear_all();
        req(5, 0, 16'h0042, 2, 1);
        rd_chk("R10 default restored", 8'h44, 1);
        traffic(200);

        // R11: enables
        phase = "R11";
        wr(8'h00, 32'h3b);
        traffic(100);
        wr(8'h00, 32'h00);
        traffic(100);
        rd_chk("R11 held", 8'h42, m_cnt[1] & 64'hffff_ffff);
        wr(8'h00, 32'h3f);

        // R12 and R2: unused codes and clear priority
        phase = "R12";
        cfg(0, 3'd5, 0, 0);
        cfg(1, 3'd7, 0, 0);
        clear_all();
        traffic(100);
        rd_chk("R2 code 5 idle", 8'h40, 0);
        rd_chk("R2 code 7 idle", 8'h42, 0);
        cfg(2, 3'd4, 0, 0);
        req_valid = 1; req_is_write = 0;
        wr(8'h44, 0);
        rd_chk("R12 clear wins", 8'h44, 0);
        traffic(100);
        for (int k = 0; k < NC; k++) rd_chk("R12 low word", 8'(8'h40 + 2*k), 64'(m_cnt[k][31:0]));
        rd_chk("R12 cycle high", 8'h61, 64'(m_cyc >> 32));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule